// File: doc/BRIEF.md
# Prioritized Interrupt Entry Controller

This block sits beside a processor pipeline and decides, every cycle, whether the interrupt level presented to it may be taken. If it may, the block makes every state change that entering the handler involves, all on one clock edge. It saves the return PC and status word, writes the exception-cause register, forms the new status word and computes the target vector address. A pulse tells the pipeline to redirect fetch to the new PC.

Levels above one go straight to their own vector and use their own pair of save registers. Level one has no vector of its own. It becomes a user, kernel or double exception, depending on the user-mode and exception-mode bits of the incoming status word. The vectors are parameters. They can be relocated at run time through a vector-base input. An option chooses whether double exceptions keep their return PC in a dedicated register.

Top module: `intr_entry_ctrl`

## Requirements
- R1: An entry is accepted only when all four of these hold: `pend_lvl` is greater than the status-word interrupt-level field (`cur_ps[3:0]`); `pend_lvl` is at most `NUM_LEVELS`; `lvl_mask_tbl[(L-1)*IRQ_W +: IRQ_W] & irq_set & irq_en` is non-zero for L = `pend_lvl`; and the selected class has a non-zero configured vector. Otherwise no output or save register changes.
- R2: An accepted level L greater than 1 does the following. It writes `cur_pc` to `save_pc_flat` slice L-1 and `cur_ps` to `save_ps_flat` slice L-2. It sets `next_ps` to `cur_ps` with bits [3:0] replaced by L and bit 4 set. It reports `exc_class` 4.
- R3: An accepted level-1 entry loads `exc_cause` with 4 and passes bits [3:0] of the status word through unchanged.
- R4: A level-1 entry with status bit 4 (exception mode) set is a double exception (`exc_class` 3). Its PC goes to `dbl_pc` when `HAS_DBL_PC` is 1. Otherwise it goes to `save_pc_flat` slice 0.
- R5: A level-1 entry with bit 4 clear saves the PC in `save_pc_flat` slice 0. It is a user exception (`exc_class` 1) when status bit 5 is set, and a kernel exception (`exc_class` 2) when bit 5 is clear.
- R6: Every level-1 entry sets bit 4 of `next_ps` and leaves every other status bit as it was.
- R7: With `RELOC_EN`=1 the new PC is the configured vector minus `RESET_VECBASE` plus `vec_base`. With `RELOC_EN`=0 it is the configured vector unchanged.
- R8: A class whose configured vector is zero is refused. `taken` stays low, and `next_pc` and all save registers hold their values.
- R9: `taken` is high for exactly one cycle per accepted entry, and every update appears after that same edge. No entry is accepted in the cycle right after `taken`.
- R10: Reset clears all save registers, `dbl_pc`, `exc_cause`, `next_pc` and `exc_class` (0 = none). It sets `next_ps` to 0x001F, which has exception mode set and an all-ones level field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_lvl | input | 3 | Level of the highest pending interrupt, 0 when none |
| cur_ps | input | PS_W | Current status word |
| irq_set | input | IRQ_W | Pending interrupt lines |
| irq_en | input | IRQ_W | Interrupt enable mask |
| lvl_mask_tbl | input | NUM_LEVELS*IRQ_W | Per-level line mask, slice L-1 for level L |
| cur_pc | input | ADDR_W | PC to save on entry |
| vec_base | input | ADDR_W | Run-time vector base |
| taken | output | 1 | One-cycle entry pulse |
| exc_class | output | 3 | Class of last entry: 0 none, 1 user, 2 kernel, 3 double, 4 high level |
| next_pc | output | ADDR_W | Handler address of last entry |
| next_ps | output | PS_W | Status word after last entry |
| save_pc_flat | output | NUM_LEVELS*ADDR_W | Per-level saved PC, slice L-1 |
| save_ps_flat | output | (NUM_LEVELS-1)*PS_W | Saved status word for levels 2 and up, slice L-2 |
| dbl_pc | output | ADDR_W | Double-exception saved PC |
| exc_cause | output | 6 | Exception-cause register |

## Verification
The bench probes the edges of the acceptance rule. It presents a level equal to the current level, a level beyond the configured count, and a mask whose enable bit is missing. A comparison that is off by one, or a mask that skips the enable, would take an interrupt that must wait. Level-1 entries are driven under each of the user, kernel and exception-mode status combinations. A design that routes the double-exception PC to the wrong register, or that touches the level field, shows a wrong save value or status word. A second instance without relocation, without the double PC register and with a zero user vector checks the relocation formula and the refusal of a zero vector. It also checks that a held request makes only one `taken` pulse.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;

   localparam int LVL_W       = 3;
   localparam int PS_ILVL_W   = 4;
   localparam int PS_EXCM_BIT = 4;
   localparam int PS_UM_BIT   = 5;
   localparam int CAUSE_W     = 6;
   localparam logic [CAUSE_W-1:0] LVL1_CAUSE = 6'd4;

   typedef enum logic [2:0] {
      CLS_NONE   = 3'd0,
      CLS_USER   = 3'd1,
      CLS_KERNEL = 3'd2,
      CLS_DOUBLE = 3'd3,
      CLS_HIGH   = 3'd4
   } exc_class_e;

endpackage

// File: rtl/intr_accept.sv
module intr_accept
   import intr_entry_pkg::*;
#(
   parameter int NUM_LEVELS = 5,
   parameter int IRQ_W      = 32
) (
   input  logic [LVL_W-1:0]            pend_lvl,
   input  logic [PS_ILVL_W-1:0]        cur_lvl,
   input  logic [IRQ_W-1:0]            irq_set,
   input  logic [IRQ_W-1:0]            irq_en,
   input  logic [NUM_LEVELS*IRQ_W-1:0] mask_tbl,
   output logic                        lvl_ok
);

   logic [NUM_LEVELS-1:0] lvl_hit;
   logic                  sel_hit;
   logic                  above_cur;
   logic                  in_range;

   // one reduction per configured level
   for (genvar gi = 0; gi < NUM_LEVELS; gi++) begin : g_hit
      assign lvl_hit[gi] = |(mask_tbl[gi*IRQ_W +: IRQ_W] & irq_set & irq_en);
   end

   always_comb begin
      sel_hit = 1'b0;
      for (int i = 0; i < NUM_LEVELS; i++) begin
         if (pend_lvl == LVL_W'(i + 1)) sel_hit = lvl_hit[i];
      end
   end

   assign above_cur = {1'b0, pend_lvl} > cur_lvl;
   assign in_range  = (pend_lvl != '0) && (pend_lvl <= LVL_W'(NUM_LEVELS));
   assign lvl_ok    = above_cur && in_range && sel_hit;

endmodule

// File: rtl/intr_vec_sel.sv
module intr_vec_sel
   import intr_entry_pkg::*;
#(
   parameter int               NUM_LEVELS    = 5,
   parameter int               ADDR_W        = 32,
   parameter bit               RELOC_EN      = 1'b1,
   parameter logic [31:0]      RESET_VECBASE = 32'h0000_0100,
   parameter logic [7:0][31:0] LVL_VEC       = {32'h2C0, 32'h280, 32'h240, 32'h200,
                                                32'h1C0, 32'h180, 32'h0, 32'h0},
   parameter logic [31:0]      VEC_USER      = 32'h340,
   parameter logic [31:0]      VEC_KERNEL    = 32'h300,
   parameter logic [31:0]      VEC_DOUBLE    = 32'h3C0
) (
   input  logic [LVL_W-1:0]  pend_lvl,
   input  logic              ps_excm,
   input  logic              ps_um,
   input  logic [ADDR_W-1:0] vec_base,
   output exc_class_e        cls,
   output logic [ADDR_W-1:0] tgt_pc,
   output logic              vec_nz
);

   logic [ADDR_W-1:0] cfg_vec;

   always_comb begin
      if (pend_lvl == LVL_W'(1)) begin
         if (ps_excm)    cls = CLS_DOUBLE;
         else if (ps_um) cls = CLS_USER;
         else            cls = CLS_KERNEL;
      end else begin
         cls = CLS_HIGH;
      end
   end

   always_comb begin
      cfg_vec = '0;
      unique case (cls)
         CLS_USER:   cfg_vec = VEC_USER[ADDR_W-1:0];
         CLS_KERNEL: cfg_vec = VEC_KERNEL[ADDR_W-1:0];
         CLS_DOUBLE: cfg_vec = VEC_DOUBLE[ADDR_W-1:0];
         default: begin
            for (int i = 2; i <= NUM_LEVELS; i++) begin
               if (pend_lvl == LVL_W'(i)) cfg_vec = LVL_VEC[i][ADDR_W-1:0];
            end
         end
      endcase
   end

   assign vec_nz = (cfg_vec != '0);

   if (RELOC_EN) begin : g_reloc
      assign tgt_pc = cfg_vec - RESET_VECBASE[ADDR_W-1:0] + vec_base;
   end else begin : g_fixed
      logic unused_base;
      assign unused_base = ^vec_base;
      assign tgt_pc      = cfg_vec;
   end

endmodule

// File: rtl/intr_save_bank.sv
module intr_save_bank
   import intr_entry_pkg::*;
#(
   parameter int NUM_LEVELS = 5,
   parameter int ADDR_W     = 32,
   parameter int PS_W       = 16,
   parameter bit HAS_DBL_PC = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           commit,
   input  logic [LVL_W-1:0]               pend_lvl,
   input  exc_class_e                     cls,
   input  logic [ADDR_W-1:0]              cur_pc,
   input  logic [PS_W-1:0]                cur_ps,
   output logic [NUM_LEVELS*ADDR_W-1:0]   save_pc_flat,
   output logic [(NUM_LEVELS-1)*PS_W-1:0] save_ps_flat,
   output logic [ADDR_W-1:0]              dbl_pc,
   output logic [CAUSE_W-1:0]             exc_cause
);

   logic lvl1_entry;
   logic lvl1_pc_wr;

   assign lvl1_entry = commit && (cls != CLS_HIGH);
   assign lvl1_pc_wr = commit && ((cls == CLS_USER) || (cls == CLS_KERNEL) ||
                                  ((cls == CLS_DOUBLE) && !HAS_DBL_PC));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         save_pc_flat[0 +: ADDR_W] <= '0;
      end else if (lvl1_pc_wr) begin
         save_pc_flat[0 +: ADDR_W] <= cur_pc;
      end
   end

   for (genvar gl = 2; gl <= NUM_LEVELS; gl++) begin : g_lvl
      logic wr;
      assign wr = commit && (cls == CLS_HIGH) && (pend_lvl == LVL_W'(gl));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            save_pc_flat[(gl-1)*ADDR_W +: ADDR_W] <= '0;
            save_ps_flat[(gl-2)*PS_W +: PS_W]     <= '0;
         end else if (wr) begin
            save_pc_flat[(gl-1)*ADDR_W +: ADDR_W] <= cur_pc;
            save_ps_flat[(gl-2)*PS_W +: PS_W]     <= cur_ps;
         end
      end
   end

   if (HAS_DBL_PC) begin : g_dbl
      always_ff @(posedge clk) begin
         if (!rst_n)                             dbl_pc <= '0;
         else if (commit && cls == CLS_DOUBLE)   dbl_pc <= cur_pc;
      end
   end else begin : g_no_dbl
      assign dbl_pc = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          exc_cause <= '0;
      else if (lvl1_entry) exc_cause <= LVL1_CAUSE;
   end

   AST_CAUSE_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
      lvl1_entry |=> exc_cause == LVL1_CAUSE); // R3

   AST_LVL1_SAVE_HOLDS_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && cls == CLS_HIGH) |=> $stable(save_pc_flat[0 +: ADDR_W])); // R2

endmodule

// File: rtl/intr_entry_ctrl.sv
module intr_entry_ctrl
   import intr_entry_pkg::*;
#(
   parameter int               NUM_LEVELS    = 5,
   parameter int               IRQ_W         = 32,
   parameter int               ADDR_W        = 32,
   parameter int               PS_W          = 16,
   parameter bit               HAS_DBL_PC    = 1'b1,
   parameter bit               RELOC_EN      = 1'b1,
   parameter logic [31:0]      RESET_VECBASE = 32'h0000_0100,
   parameter logic [7:0][31:0] LVL_VEC       = {32'h2C0, 32'h280, 32'h240, 32'h200,
                                                32'h1C0, 32'h180, 32'h0, 32'h0},
   parameter logic [31:0]      VEC_USER      = 32'h340,
   parameter logic [31:0]      VEC_KERNEL    = 32'h300,
   parameter logic [31:0]      VEC_DOUBLE    = 32'h3C0
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [2:0]                     pend_lvl,
   input  logic [PS_W-1:0]                cur_ps,
   input  logic [IRQ_W-1:0]               irq_set,
   input  logic [IRQ_W-1:0]               irq_en,
   input  logic [NUM_LEVELS*IRQ_W-1:0]    lvl_mask_tbl,
   input  logic [ADDR_W-1:0]              cur_pc,
   input  logic [ADDR_W-1:0]              vec_base,
   output logic                           taken,
   output logic [2:0]                     exc_class,
   output logic [ADDR_W-1:0]              next_pc,
   output logic [PS_W-1:0]                next_ps,
   output logic [NUM_LEVELS*ADDR_W-1:0]   save_pc_flat,
   output logic [(NUM_LEVELS-1)*PS_W-1:0] save_ps_flat,
   output logic [ADDR_W-1:0]              dbl_pc,
   output logic [5:0]                     exc_cause
);

   localparam logic [PS_W-1:0] PS_RESET =
      PS_W'({1'b1, {PS_ILVL_W{1'b1}}});

   if (NUM_LEVELS < 2 || NUM_LEVELS > 7) begin : g_bad_levels
      $error("NUM_LEVELS must lie in 2..7");
   end
   if (PS_W < PS_UM_BIT + 1) begin : g_bad_ps
      $error("PS_W too narrow for status fields");
   end
   if (ADDR_W > 32 || ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must lie in 8..32");
   end

   logic              lvl_ok;
   logic              vec_nz;
   logic              commit;
   exc_class_e        cls_sel;
   exc_class_e        cls_q;
   logic [ADDR_W-1:0] tgt_pc;
   logic [PS_W-1:0]   ps_new;

   intr_accept #(
      .NUM_LEVELS (NUM_LEVELS),
      .IRQ_W      (IRQ_W)
   ) u_accept (
      .pend_lvl (pend_lvl),
      .cur_lvl  (cur_ps[PS_ILVL_W-1:0]),
      .irq_set  (irq_set),
      .irq_en   (irq_en),
      .mask_tbl (lvl_mask_tbl),
      .lvl_ok   (lvl_ok)
   );

   intr_vec_sel #(
      .NUM_LEVELS    (NUM_LEVELS),
      .ADDR_W        (ADDR_W),
      .RELOC_EN      (RELOC_EN),
      .RESET_VECBASE (RESET_VECBASE),
      .LVL_VEC       (LVL_VEC),
      .VEC_USER      (VEC_USER),
      .VEC_KERNEL    (VEC_KERNEL),
      .VEC_DOUBLE    (VEC_DOUBLE)
   ) u_vec (
      .pend_lvl (pend_lvl),
      .ps_excm  (cur_ps[PS_EXCM_BIT]),
      .ps_um    (cur_ps[PS_UM_BIT]),
      .vec_base (vec_base),
      .cls      (cls_sel),
      .tgt_pc   (tgt_pc),
      .vec_nz   (vec_nz)
   );

   // the cycle after a pulse belongs to the pipeline redirect
   assign commit = lvl_ok && vec_nz && !taken;

   always_comb begin
      ps_new = cur_ps;
      ps_new[PS_EXCM_BIT] = 1'b1;
      if (cls_sel == CLS_HIGH) begin
         ps_new[PS_ILVL_W-1:0] = PS_ILVL_W'(pend_lvl);
      end
   end

   intr_save_bank #(
      .NUM_LEVELS (NUM_LEVELS),
      .ADDR_W     (ADDR_W),
      .PS_W       (PS_W),
      .HAS_DBL_PC (HAS_DBL_PC)
   ) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .commit       (commit),
      .pend_lvl     (pend_lvl),
      .cls          (cls_sel),
      .cur_pc       (cur_pc),
      .cur_ps       (cur_ps),
      .save_pc_flat (save_pc_flat),
      .save_ps_flat (save_ps_flat),
      .dbl_pc       (dbl_pc),
      .exc_cause    (exc_cause)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         taken   <= 1'b0;
         cls_q   <= CLS_NONE;
         next_pc <= '0;
         next_ps <= PS_RESET;
      end else begin
         taken <= commit;
         if (commit) begin
            cls_q   <= cls_sel;
            next_pc <= tgt_pc;
            next_ps <= ps_new;
         end
      end
   end

   assign exc_class = cls_q;

   AST_TAKEN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      taken |=> !taken); // R9

   AST_ACCEPT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(taken) |-> {1'b0, $past(pend_lvl)} > $past(cur_ps[PS_ILVL_W-1:0])); // R1

   AST_EXCM_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      taken |-> next_ps[PS_EXCM_BIT]); // R6

   AST_LVL1_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(taken) && $past(pend_lvl) == 3'd1) |->
         next_ps[PS_ILVL_W-1:0] == $past(cur_ps[PS_ILVL_W-1:0])); // R3

   AST_DOUBLE_ON_EXCM: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(taken) && $past(pend_lvl) == 3'd1 && $past(cur_ps[PS_EXCM_BIT])) |->
         cls_q == CLS_DOUBLE); // R4

   AST_PC_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!taken && $past(rst_n) && !$rose(taken)) |-> $stable(next_pc) || $rose(taken)); // R8

endmodule

// File: tb/intr_entry_ctrl_tb.sv
module intr_entry_ctrl_tb;

   localparam int IRQ_W = 32;
   localparam int AW    = 32;
   localparam int PSW   = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [2:0]        pend_lvl = '0;
   logic [PSW-1:0]    cur_ps = '0;
   logic [IRQ_W-1:0]  irq_set = '0;
   logic [IRQ_W-1:0]  irq_en = '0;
   logic [5*IRQ_W-1:0] mask1 = '0;
   logic [3*IRQ_W-1:0] mask2;
   logic [AW-1:0]     cur_pc = '0;
   logic [AW-1:0]     vec_base = '0;

   logic              tk1, tk2;
   logic [2:0]        cl1, cl2;
   logic [AW-1:0]     npc1, npc2, dpc1, dpc2;
   logic [PSW-1:0]    nps1, nps2;
   logic [5*AW-1:0]   spc1;
   logic [3*AW-1:0]   spc2;
   logic [4*PSW-1:0]  sps1;
   logic [2*PSW-1:0]  sps2;
   logic [5:0]        cause1, cause2;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   assign mask2 = mask1[3*IRQ_W-1:0];

   always #2 clk = ~clk;

   intr_entry_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .pend_lvl(pend_lvl), .cur_ps(cur_ps),
      .irq_set(irq_set), .irq_en(irq_en), .lvl_mask_tbl(mask1),
      .cur_pc(cur_pc), .vec_base(vec_base), .taken(tk1), .exc_class(cl1),
      .next_pc(npc1), .next_ps(nps1), .save_pc_flat(spc1),
      .save_ps_flat(sps1), .dbl_pc(dpc1), .exc_cause(cause1)
   );

   intr_entry_ctrl #(
      .NUM_LEVELS (3),
      .HAS_DBL_PC (1'b0),
      .RELOC_EN   (1'b0),
      .VEC_USER   (32'h0)
   ) u_dut2 (
      .clk(clk), .rst_n(rst_n), .pend_lvl(pend_lvl), .cur_ps(cur_ps),
      .irq_set(irq_set), .irq_en(irq_en), .lvl_mask_tbl(mask2),
      .cur_pc(cur_pc), .vec_base(vec_base), .taken(tk2), .exc_class(cl2),
      .next_pc(npc2), .next_ps(nps2), .save_pc_flat(spc2),
      .save_ps_flat(sps2), .dbl_pc(dpc2), .exc_cause(cause2)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      pend_lvl = '0;
      mask1    = '0;
      irq_set  = '0;
      irq_en   = '0;
      step();
      step();
   endtask

   task automatic t_reset();
      check("R10 taken", 64'(tk1), 64'd0);
      check("R10 next_ps", 64'(nps1), 64'h001F);
      check("R10 class", 64'(cl1), 64'd0);
      check("R10 next_pc", 64'(npc1), 64'd0);
      check("R10 save_pc", 64'(spc1[63:0]), 64'd0);
      check("R10 cause", 64'(cause1), 64'd0);
      check("R10 dbl_pc", 64'(dpc1), 64'd0);
      check("R10 dut2 next_ps", 64'(nps2), 64'h001F);
   endtask

   task automatic t_high();
      vec_base = 32'h4000_0000;
      cur_ps   = 16'h0002;
      pend_lvl = 3'd4;
      mask1[3*IRQ_W +: IRQ_W] = 32'h10;
      irq_set  = 32'h10;
      irq_en   = 32'h10;
      cur_pc   = 32'h1234;
      step();
      check("R2 taken", 64'(tk1), 64'd1);
      check("R7 reloc pc", 64'(npc1), 64'h4000_0100);
      check("R2 next_ps", 64'(nps1), 64'h0014);
      check("R2 save_pc l4", 64'(spc1[3*AW +: AW]), 64'h1234);
      check("R2 save_ps l4", 64'(sps1[2*PSW +: PSW]), 64'h0002);
      check("R2 class", 64'(cl1), 64'd4);
      check("R1 dut2 level beyond count", 64'(tk2), 64'd0);
      step();
      check("R9 single pulse", 64'(tk1), 64'd0);
      idle();
   endtask

   task automatic t_reject();
      cur_ps   = 16'h0004;
      pend_lvl = 3'd4;
      mask1[3*IRQ_W +: IRQ_W] = 32'h10;
      irq_set  = 32'h10;
      irq_en   = 32'h10;
      step();
      check("R1 equal level", 64'(tk1), 64'd0);
      step();
      check("R1 equal level held", 64'(tk1), 64'd0);
      cur_ps   = 16'h0000;
      pend_lvl = 3'd6;
      mask1    = '1;
      irq_set  = '1;
      irq_en   = '1;
      step();
      check("R1 above count", 64'(tk1), 64'd0);
      check("R1 above count dut2", 64'(tk2), 64'd0);
      mask1    = '0;
      pend_lvl = 3'd3;
      mask1[2*IRQ_W +: IRQ_W] = 32'h100;
      irq_set  = 32'h100;
      irq_en   = 32'h0FF;
      step();
      check("R1 enable missing", 64'(tk1), 64'd0);
      check("R1 pc held", 64'(npc1), 64'h4000_0100);
      idle();
   endtask

   task automatic t_lvl1(input logic [PSW-1:0] ps, input logic [AW-1:0] pc);
      cur_ps   = ps;
      pend_lvl = 3'd1;
      mask1[0 +: IRQ_W] = 32'h1;
      irq_set  = 32'h1;
      irq_en   = 32'h1;
      cur_pc   = pc;
      step();
   endtask

   task automatic t_kernel();
      t_lvl1(16'h0100, 32'hA0);
      check("R5 kernel taken", 64'(tk1), 64'd1);
      check("R5 kernel class", 64'(cl1), 64'd2);
      check("R7 kernel pc", 64'(npc1), 64'h4000_0200);
      check("R3 cause", 64'(cause1), 64'd4);
      check("R5 save_pc l1", 64'(spc1[0 +: AW]), 64'hA0);
      check("R6 next_ps", 64'(nps1), 64'h0110);
      check("R7 dut2 kernel pc", 64'(npc2), 64'h300);
      idle();
   endtask

   task automatic t_user();
      t_lvl1(16'h0020, 32'hC0);
      check("R5 user class", 64'(cl1), 64'd1);
      check("R7 user pc", 64'(npc1), 64'h4000_0240);
      check("R6 user next_ps", 64'(nps1), 64'h0030);
      check("R5 user save_pc", 64'(spc1[0 +: AW]), 64'hC0);
      check("R8 dut2 refused", 64'(tk2), 64'd0);
      check("R8 dut2 pc held", 64'(npc2), 64'h300);
      check("R8 dut2 class held", 64'(cl2), 64'd2);
      check("R8 dut2 save held", 64'(spc2[0 +: AW]), 64'hA0);
      idle();
   endtask

   task automatic t_double();
      t_lvl1(16'h0010, 32'hB0);
      check("R4 double class", 64'(cl1), 64'd3);
      check("R4 double pc", 64'(npc1), 64'h4000_02C0);
      check("R4 dbl_pc", 64'(dpc1), 64'hB0);
      check("R4 save_pc l1 untouched", 64'(spc1[0 +: AW]), 64'hC0);
      check("R3 double next_ps", 64'(nps1), 64'h0010);
      check("R4 dut2 class", 64'(cl2), 64'd3);
      check("R4 dut2 pc", 64'(npc2), 64'h3C0);
      check("R4 dut2 save_pc l1", 64'(spc2[0 +: AW]), 64'hB0);
      idle();
   endtask

   task automatic t_reloc();
      cur_ps   = 16'h0000;
      pend_lvl = 3'd2;
      mask1[1*IRQ_W +: IRQ_W] = 32'h4;
      irq_set  = 32'h4;
      irq_en   = 32'h4;
      cur_pc   = 32'hD0;
      step();
      check("R7 dut2 fixed pc", 64'(npc2), 64'h180);
      check("R2 dut2 next_ps", 64'(nps2), 64'h0012);
      check("R2 dut2 save_pc l2", 64'(spc2[1*AW +: AW]), 64'hD0);
      check("R7 dut1 reloc pc", 64'(npc1), 64'h4000_0080);
      idle();
      vec_base = 32'h2000_0000;
      pend_lvl = 3'd2;
      mask1[1*IRQ_W +: IRQ_W] = 32'h4;
      irq_set  = 32'h4;
      irq_en   = 32'h4;
      step();
      check("R7 new base", 64'(npc1), 64'h2000_0080);
      check("R7 dut2 base ignored", 64'(npc2), 64'h180);
      idle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_high();
      t_reject();
      t_kernel();
      t_user();
      t_double();
      t_reloc();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule